// File: doc/BRIEF.md
# Row State Multiplexer and Packer

This block sits after the per-group sparse encoders of a pixel sensor read-out. A row of 960 columns is split into 15 groups of 64 columns. For each group the encoders report how many strings of hit pixels they found, up to six, and one 8-bit descriptor per string. Each descriptor holds a 2-bit pixel-count code and a 6-bit column address relative to its group. When a row is presented, the block gathers these strings into one list for the whole row. It keeps no more than nine strings and turns every group-relative address into an absolute 10-bit column.

Each row that holds at least one string becomes a header word followed by its string words, all 16 bits wide. The header carries the row number, the number of strings kept and an overflow flag. The words are paired into 32-bit writes for two 16-bit memory halves and issued on consecutive cycles. A write address counter steps once per write and is cleared by a frame-start pulse. A row with no strings writes nothing.

Top module: `row_state_packer`

## Requirements
- R1: A row presented with every group count at zero produces no memory write.
- R2: The header word has the kept-string count in bits 3:0, the overflow flag in bit 4, the row number in bits 14:5 and zero in bit 15. It is always the low half of the row's first write.
- R3: At most nine strings are kept per row. The overflow flag is 1 exactly when the counts of all groups add up to more than nine.
- R4: A string word has the pixel-count code in bits 1:0, the absolute column (group index times 64 plus the local address) in bits 11:2, and zero in bits 15:12.
- R5: Strings are taken in ascending group order, and within a group in ascending descriptor index. The first word of each pair goes to bits 15:0 and the second to bits 31:16.
- R6: When a row has an odd number of words (header plus strings), the upper half of its last write is zero.
- R7: The writes of a row occupy consecutive cycles, starting the cycle after the row strobe. A row with N kept strings makes (N+2)/2 writes, rounded down.
- R8: The write address rises by one after each write and holds while no write is made.
- R9: The frame-start pulse makes the next write use address 0. A write made in the same cycle as the pulse still uses the current address.
- R10: A row strobe may fall in the last write cycle of the previous row. That pair is still written, and the new row's writes begin on the next cycle.
- R11: After reset no write is pending and the address is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Clears the write address counter |
| row_valid | input | 1 | One-cycle strobe: row inputs are valid |
| row_num | input | 10 | Row number of the presented row |
| grp_cnt | input | 45 | Per-group string counts, 3 bits per group, group g at bits 3g+2:3g |
| grp_state | input | 720 | Descriptors, 8 bits each, group g index j at bit 8(6g+j); code in 1:0, local address in 7:2 |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 11 | Memory write address |
| mem_data | output | 32 | Word pair: first word in 15:0, second in 31:16 |

## Verification
Two events can fall in the same cycle, and both are driven on purpose. A frame-start pulse is driven during the first write of a two-write row. That write must still carry the old address, and the following write must land at address 0. A new row strobe is driven during the single write cycle of a short row. The pair on the bus in that cycle must still belong to the old row, and the new row's pairs must follow without a gap. All words are compared against a model of the header and string formats that the bench builds itself.

// File: rtl/row_state_packer.sv
`timescale 1ns/1ps
module row_state_packer #(
  parameter int NGRP    = 15,
  parameter int GSTATES = 6,
  parameter int GCW     = 3,
  parameter int LOCW    = 6,
  parameter int COLW    = 10,
  parameter int ROWW    = 10,
  parameter int MAXST   = 9,
  parameter int ADRW    = 11
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          frame_start,
  input  logic                          row_valid,
  input  logic [ROWW-1:0]               row_num,
  input  logic [NGRP*GCW-1:0]           grp_cnt,
  input  logic [NGRP*GSTATES*(LOCW+2)-1:0] grp_state,
  output logic                          mem_we,
  output logic [ADRW-1:0]               mem_addr,
  output logic [31:0]                   mem_data
);
  localparam int SW    = LOCW + 2;
  localparam int CW    = $clog2(MAXST + 1);
  localparam int NPAIR = (MAXST + 2) / 2;
  localparam int NWB   = 2 * NPAIR;
  localparam int PW    = $clog2(NPAIR + 1);

  logic [15:0]   nxt  [NWB];
  logic [15:0]   wbuf [NWB];
  logic [PW-1:0] nxt_pairs, npairs, pidx;

  always_comb begin
    int tot;
    int kept;
    tot = 0;
    for (int i = 0; i < NWB; i++) nxt[i] = '0;
    for (int g = 0; g < NGRP; g++) begin
      for (int j = 0; j < GSTATES; j++) begin
        if (j < int'(grp_cnt[g*GCW +: GCW])) begin
          if (tot < MAXST)
            nxt[tot+1] = {{(16-COLW-2){1'b0}},
                          COLW'(g * (2**LOCW) + int'(grp_state[(g*GSTATES+j)*SW+2 +: LOCW])),
                          grp_state[(g*GSTATES+j)*SW +: 2]};
          tot++;
        end
      end
    end
    kept = (tot > MAXST) ? MAXST : tot;
    nxt[0] = {{(16-ROWW-CW-1){1'b0}}, row_num, (tot > MAXST), CW'(kept)};
    nxt_pairs = (tot == 0) ? '0 : PW'((kept + 2) / 2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      npairs   <= '0;
      pidx     <= '0;
      mem_addr <= '0;
      for (int i = 0; i < NWB; i++) wbuf[i] <= '0;
    end else begin
      if (row_valid) begin
        wbuf   <= nxt;
        npairs <= nxt_pairs;
        pidx   <= '0;
      end else if (mem_we) begin
        pidx <= pidx + 1'b1;
      end
      if (frame_start)  mem_addr <= '0;
      else if (mem_we)  mem_addr <= mem_addr + 1'b1;
    end
  end

  assign mem_we   = (pidx < npairs);
  assign mem_data = {wbuf[2*int'(pidx)+1], wbuf[2*int'(pidx)]};
endmodule

// File: rtl/row_state_packer_chk.sv
`timescale 1ns/1ps
module row_state_packer_chk #(
  parameter int NGRP = 15,
  parameter int GCW  = 3,
  parameter int ADRW = 11
) (
  input logic                clk,
  input logic                rst_n,
  input logic                frame_start,
  input logic                row_valid,
  input logic [NGRP*GCW-1:0] grp_cnt,
  input logic                mem_we,
  input logic [ADRW-1:0]     mem_addr,
  input logic [31:0]         mem_data
);
  p_empty_row_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (row_valid && grp_cnt == '0) |=> !mem_we);

  p_spare_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_data[15] == 1'b0 && mem_data[31:28] == 4'd0));

  p_first_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (row_valid && grp_cnt != '0) |=> mem_we);

  p_addr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !frame_start) |=> mem_addr == $past(mem_addr) + 1'b1);

  p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we && !frame_start) |=> $stable(mem_addr));

  p_frame_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> mem_addr == '0);
endmodule

bind row_state_packer row_state_packer_chk #(.NGRP(NGRP), .GCW(GCW), .ADRW(ADRW)) u_chk (.*);

// File: tb/test_row_state_packer.sv
`timescale 1ns/1ps
module test_row_state_packer;
  logic         clk = 0, rst_n = 0, frame_start = 0, row_valid = 0;
  logic [9:0]   row_num = '0;
  logic [44:0]  grp_cnt = '0;
  logic [719:0] grp_state;
  logic         mem_we;
  logic [10:0]  mem_addr;
  logic [31:0]  mem_data;

  row_state_packer i_row_state_packer (.*);

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0, exp_addr = 0, enp = 0;
  int cnt_tb [15];
  logic [15:0] ew [12];

  // Vector: [31:22] row, [21:18] group A, [17:15] count A, [14:11] group B, [10:8] count B
  localparam logic [31:0] VEC [7] = '{
    {10'd5,   4'd0,  3'd1, 4'd14, 3'd0, 8'd0},
    {10'd927, 4'd3,  3'd2, 4'd7,  3'd1, 8'd0},
    {10'd0,   4'd0,  3'd0, 4'd1,  3'd0, 8'd0},
    {10'd100, 4'd2,  3'd6, 4'd9,  3'd3, 8'd0},
    {10'd200, 4'd14, 3'd6, 4'd13, 3'd6, 8'd0},
    {10'd512, 4'd5,  3'd6, 4'd6,  3'd4, 8'd0},
    {10'd1,   4'd14, 3'd6, 4'd0,  3'd0, 8'd0}
  };

  function automatic int loc_of(int g, int j); return (g*7 + j*11) % 64; endfunction
  function automatic int code_of(int g, int j); return (g + j) % 4; endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [9:0] row);
    int tot, nw;
    tot = 0;
    for (int i = 0; i < 12; i++) ew[i] = '0;
    for (int g = 0; g < 15; g++)
      for (int j = 0; j < cnt_tb[g]; j++) begin
        if (tot < 9) ew[tot+1] = {4'd0, 10'(g*64 + loc_of(g, j)), 2'(code_of(g, j))};
        tot++;
      end
    nw = (tot > 9) ? 9 : tot;
    ew[0] = {1'b0, row, (tot > 9), 4'(nw)};
    enp = (tot == 0) ? 0 : (nw + 2) / 2;
  endtask

  task automatic drive(input logic [9:0] row);
    row_num = row;
    for (int g = 0; g < 15; g++) grp_cnt[g*3 +: 3] = 3'(cnt_tb[g]);
  endtask

  task automatic expect_writes(input string tag);
    for (int p = 0; p < enp; p++) begin
      chk(32'(mem_we), 32'd1, {tag, " R7 write enable"});
      chk(32'(mem_addr), 32'(exp_addr), {tag, " R8 address"});
      chk(mem_data, {ew[2*p+1], ew[2*p]}, {tag, " R2 R3 R4 R5 R6 words"});
      exp_addr = (exp_addr + 1) % 2048;
      @(negedge clk);
    end
    chk(32'(mem_we), 32'd0, {tag, " R1 R7 idle after row"});
  endtask

  task automatic run_row(input logic [9:0] row, input string tag);
    @(negedge clk);
    model(row);
    drive(row);
    row_valid = 1;
    @(negedge clk);
    row_valid = 0;
    expect_writes(tag);
  endtask

  task automatic clear_cnt();
    for (int g = 0; g < 15; g++) cnt_tb[g] = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] save_a;
    for (int g = 0; g < 15; g++)
      for (int j = 0; j < 6; j++)
        grp_state[(g*6+j)*8 +: 8] = {6'(loc_of(g, j)), 2'(code_of(g, j))};
    repeat (3) @(negedge clk);
    chk(32'(mem_we), 32'd0, "R11 reset write enable");
    chk(32'(mem_addr), 32'd0, "R11 reset address");
    rst_n = 1;
    @(negedge clk);
    chk(32'(mem_we), 32'd0, "R11 idle after reset");

    foreach (VEC[v]) begin
      clear_cnt();
      cnt_tb[VEC[v][21:18]] = int'(VEC[v][17:15]);
      cnt_tb[VEC[v][14:11]] = int'(VEC[v][10:8]);
      run_row(VEC[v][31:22], $sformatf("vec%0d", v));
    end

    // R3: every group full, 90 strings found
    for (int g = 0; g < 15; g++) cnt_tb[g] = 6;
    run_row(10'd333, "R3 all groups full");

    // R9: frame start during the first of two writes
    clear_cnt(); cnt_tb[3] = 2; cnt_tb[11] = 1;
    @(negedge clk);
    model(10'd44); drive(10'd44); row_valid = 1;
    @(negedge clk);
    row_valid = 0; frame_start = 1;
    chk(32'(mem_addr), 32'(exp_addr), "R9 write in pulse cycle keeps address");
    chk(mem_data, {ew[1], ew[0]}, "R9 first pair");
    @(negedge clk);
    frame_start = 0;
    chk(32'(mem_we), 32'd1, "R9 second write present");
    chk(32'(mem_addr), 32'd0, "R9 next write at zero");
    chk(mem_data, {ew[3], ew[2]}, "R9 second pair");
    exp_addr = 1;
    @(negedge clk);
    chk(32'(mem_we), 32'd0, "R9 idle after row");

    // R10: new strobe in the last write cycle of a one-write row
    clear_cnt(); cnt_tb[4] = 1;
    @(negedge clk);
    model(10'd700); drive(10'd700); row_valid = 1;
    save_a = {ew[1], ew[0]};
    @(negedge clk);
    clear_cnt(); cnt_tb[1] = 3; cnt_tb[12] = 2;
    model(10'd701); drive(10'd701); row_valid = 1;
    chk(32'(mem_we), 32'd1, "R10 old row write present");
    chk(32'(mem_addr), 32'(exp_addr), "R10 old row address");
    chk(mem_data, save_a, "R10 old row pair kept");
    exp_addr++;
    @(negedge clk);
    row_valid = 0;
    expect_writes("R10 back-to-back row");

    // R1: empty row after activity leaves address unchanged
    clear_cnt();
    run_row(10'd9, "R1 empty row");
    clear_cnt(); cnt_tb[0] = 1;
    run_row(10'd10, "R8 address continues");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule